// File: doc/BRIEF.md
# Segmented Downward-Growing Stack Unit

This block keeps a last-in-first-out stack of 16-bit cells in an external byte-addressed memory. The top of the stack is given by a 16-bit stack segment and a 16-bit pointer offset. The physical address is the segment multiplied by sixteen plus the offset, wrapped to 20 bits. A push first lowers the pointer by one cell (two bytes) and then writes the pushed value there. A pop reads the cell at the pointer and then raises the pointer by one cell. The popped cell is not cleared, so the old value stays in memory until a later push writes over it.

Each command takes two cycles. In the first cycle the block issues a single memory request. In the second it completes the command, and for a pop it waits for the read data. A busy output marks the command in flight, and commands that arrive while busy is high are dropped. The pointer can be loaded while the block is idle, which lets software place the stack anywhere in the segment.

Top module: `seg_stack_unit`

## Requirements
- R1: After reset, sp_o equals SP_INIT (default 0000h), and busy_o, mem_req_o, pop_valid_o and cmd_err_o are all 0.
- R2: A push accepted while idle lowers sp_o by 2 (modulo 2^16). In the next cycle it issues exactly one request with mem_we_o=1 and mem_wdata_o equal to the pushed value, addressed at the new pointer.
- R3: mem_addr_o is ({segment,4'h0} + {4'h0,pointer}) modulo 2^20, using the segment sampled when the command was accepted. For example, segment 08F1h with pointer 0100h gives 09010h.
- R4: A pop accepted while idle issues one read request (mem_we_o=0) at the current pointer in the next cycle. The cycle after mem_rvalid_i is seen, pop_data_o holds mem_rdata_i and pop_valid_o is 1 for exactly one cycle, and sp_o has risen by 2.
- R5: Pops return values in the reverse of the order in which they were pushed.
- R6: A pop never writes to memory. The popped cell keeps its value, and the next push writes to that same address.
- R7: busy_o is 1 from the cycle after a command is accepted until the command completes. A push or pop raised while busy_o is 1 issues no request.
- R8: A push and a pop raised together while idle make cmd_err_o 1 for exactly one cycle. No request is issued and sp_o does not change.
- R9: sp_load_i while idle sets sp_o to sp_load_val_i in the next cycle. A push or pop raised in the same cycle is ignored.
- R10: The pointer wraps from 0000h to FFFEh on a push. With segment FFFFh and pointer FFFEh, the address wraps to 0FFEEh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| seg_i | input | 16 | Stack segment value |
| sp_load_i | input | 1 | Load the pointer (idle only) |
| sp_load_val_i | input | 16 | Value to load into the pointer |
| push_i | input | 1 | Push command strobe |
| pop_i | input | 1 | Pop command strobe |
| push_data_i | input | 16 | Value to push |
| pop_data_o | output | 16 | Last popped value |
| pop_valid_o | output | 1 | One-cycle pulse when pop_data_o is new |
| busy_o | output | 1 | A command is in flight |
| cmd_err_o | output | 1 | One-cycle pulse for a push and pop raised together |
| sp_o | output | 16 | Current pointer offset |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | 20 | Physical byte address |
| mem_wdata_o | output | 16 | Write data |
| mem_rdata_i | input | 16 | Read data |
| mem_rvalid_i | input | 1 | Read data valid |

## Verification
The first pattern places the pointer at 0102h in segment 08F1h and does one push; landing on 09010h shows that the segment is shifted by four bits and not added plainly. The second pattern is a run of three pushes followed by three pops. Checking the request addresses and the order of the returned data separates correct LIFO behaviour from FIFO order and from wrong step sizes. A pop followed by a push shows that the cell is not erased and that its address is reused. Strobes held during busy, a push and pop raised together, and a load raised alongside a push each show that a command is dropped. Segment FFFFh with pointer 0000h shows that both the pointer and the physical address wrap.

// File: rtl/seg_stack_pkg.sv
package seg_stack_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_CPLT} st_e;
  typedef enum logic {OP_PUSH, OP_POP} op_e;
endpackage

// File: rtl/seg_addr_gen.sv
module seg_addr_gen #(
  parameter int SEG_W  = 16,
  parameter int OFF_W  = 16,
  parameter int SHIFT  = 4,
  parameter int ADDR_W = 20
) (
  input  logic [SEG_W-1:0]  seg_i,
  input  logic [OFF_W-1:0]  off_i,
  output logic [ADDR_W-1:0] phys_o
);
  localparam int SUM_W = ADDR_W + 1;
  logic [SUM_W-1:0] sum;

  always_comb begin
    sum = {{(SUM_W-SEG_W-SHIFT){1'b0}}, seg_i, {SHIFT{1'b0}}}
        + {{(SUM_W-OFF_W){1'b0}}, off_i};
    phys_o = sum[ADDR_W-1:0];  // carry out of the top bit is dropped: wraps
  end
endmodule

// File: rtl/stack_ptr.sv
module stack_ptr #(
  parameter int              OFF_W   = 16,
  parameter int              STEP    = 2,
  parameter logic [OFF_W-1:0] SP_INIT = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [OFF_W-1:0] load_val_i,
  input  logic             dec_i,
  input  logic             inc_i,
  output logic [OFF_W-1:0] sp_o
);
  localparam logic [OFF_W-1:0] STEP_V = OFF_W'(STEP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sp_o <= SP_INIT;
    else if (load_i) sp_o <= load_val_i;
    else if (dec_i)  sp_o <= sp_o - STEP_V;
    else if (inc_i)  sp_o <= sp_o + STEP_V;
  end

  assert_step_down_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_i && !load_i) |=> (sp_o == $past(sp_o) - STEP_V));
  assert_step_up_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !load_i && !dec_i) |=> (sp_o == $past(sp_o) + STEP_V));
  assert_load_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (sp_o == $past(load_val_i)));
endmodule

// File: rtl/stack_ctrl.sv
module stack_ctrl
  import seg_stack_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int SEG_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic              pop_i,
  input  logic              load_i,
  input  logic [DATA_W-1:0] push_data_i,
  input  logic [SEG_W-1:0]  seg_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  input  logic              mem_rvalid_i,
  output logic              ptr_load_o,
  output logic              ptr_dec_o,
  output logic              ptr_inc_o,
  output logic [SEG_W-1:0]  seg_q_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic [DATA_W-1:0] pop_data_o,
  output logic              pop_valid_o,
  output logic              cmd_err_o,
  output logic              busy_o
);
  st_e st_q;
  op_e op_q;
  logic idle, clash, take_push, take_pop, done;

  always_comb begin
    idle       = (st_q == ST_IDLE);
    clash      = push_i && pop_i;
    ptr_load_o = idle && load_i;
    take_push  = idle && !load_i && push_i && !pop_i;
    take_pop   = idle && !load_i && pop_i && !push_i;
    ptr_dec_o  = take_push;
    ptr_inc_o  = (st_q == ST_CPLT) && (op_q == OP_POP) && mem_rvalid_i;
    done       = (st_q == ST_CPLT) && ((op_q == OP_PUSH) || mem_rvalid_i);
    mem_req_o  = (st_q == ST_ISSUE);
    mem_we_o   = (st_q == ST_ISSUE) && (op_q == OP_PUSH);
    busy_o     = !idle;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_IDLE;
      op_q        <= OP_PUSH;
      seg_q_o     <= '0;
      mem_wdata_o <= '0;
      pop_data_o  <= '0;
      pop_valid_o <= 1'b0;
      cmd_err_o   <= 1'b0;
    end else begin
      pop_valid_o <= 1'b0;
      cmd_err_o   <= idle && !load_i && clash;
      unique case (st_q)
        ST_IDLE: if (take_push || take_pop) begin
          st_q    <= ST_ISSUE;
          op_q    <= take_push ? OP_PUSH : OP_POP;
          seg_q_o <= seg_i;
          if (take_push) mem_wdata_o <= push_data_i;
        end
        ST_ISSUE: st_q <= ST_CPLT;
        ST_CPLT: if (done) begin
          st_q <= ST_IDLE;
          if (op_q == OP_POP) begin
            pop_data_o  <= mem_rdata_i;
            pop_valid_o <= 1'b1;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assert_single_req_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |=> !mem_req_o);
  assert_req_busy_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> busy_o);
  assert_err_no_req_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_err_o |-> (!mem_req_o && !busy_o));
  assert_pop_pulse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_valid_o |=> !pop_valid_o);
  assert_pop_no_write_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && op_q == OP_POP) |-> !mem_we_o);
endmodule

// File: rtl/seg_stack_unit.sv
module seg_stack_unit #(
  parameter int              DATA_W  = 16,
  parameter int              SEG_W   = 16,
  parameter int              OFF_W   = 16,
  parameter int              SHIFT   = 4,
  parameter int              ADDR_W  = 20,
  parameter logic [OFF_W-1:0] SP_INIT = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [SEG_W-1:0]  seg_i,
  input  logic              sp_load_i,
  input  logic [OFF_W-1:0]  sp_load_val_i,
  input  logic              push_i,
  input  logic              pop_i,
  input  logic [DATA_W-1:0] push_data_i,
  output logic [DATA_W-1:0] pop_data_o,
  output logic              pop_valid_o,
  output logic              busy_o,
  output logic              cmd_err_o,
  output logic [OFF_W-1:0]  sp_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  input  logic              mem_rvalid_i
);
  localparam int STEP = DATA_W / 8;  // bytes per cell

  logic             ptr_load, ptr_dec, ptr_inc;
  logic [SEG_W-1:0] seg_q;

  stack_ctrl #(.DATA_W(DATA_W), .SEG_W(SEG_W)) i_ctrl (
    .clk_i, .rst_ni, .push_i, .pop_i,
    .load_i      (sp_load_i),
    .push_data_i, .seg_i, .mem_rdata_i, .mem_rvalid_i,
    .ptr_load_o  (ptr_load),
    .ptr_dec_o   (ptr_dec),
    .ptr_inc_o   (ptr_inc),
    .seg_q_o     (seg_q),
    .mem_req_o, .mem_we_o, .mem_wdata_o,
    .pop_data_o, .pop_valid_o, .cmd_err_o, .busy_o
  );

  stack_ptr #(.OFF_W(OFF_W), .STEP(STEP), .SP_INIT(SP_INIT)) i_ptr (
    .clk_i, .rst_ni,
    .load_i     (ptr_load),
    .load_val_i (sp_load_val_i),
    .dec_i      (ptr_dec),
    .inc_i      (ptr_inc),
    .sp_o
  );

  seg_addr_gen #(.SEG_W(SEG_W), .OFF_W(OFF_W), .SHIFT(SHIFT), .ADDR_W(ADDR_W)) i_agen (
    .seg_i  (seg_q),
    .off_i  (sp_o),
    .phys_o (mem_addr_o)
  );

  assert_addr_nibble_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> (mem_addr_o[SHIFT-1:0] == sp_o[SHIFT-1:0]));
  assert_idle_no_req_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mem_req_o);
endmodule

// File: tb/test_seg_stack_unit.sv
module test_seg_stack_unit;
  typedef struct packed {logic we; logic [19:0] addr; logic [15:0] data;} req_t;

  logic        clk = 0, rst_ni = 0;
  logic [15:0] seg = 0, ld_val = 0, pdata = 0;
  logic        ld = 0, push = 0, pop = 0;
  logic [15:0] pop_data, sp, wdata, rdata = 0;
  logic        pop_valid, busy, err, req, we, rvalid = 0;
  logic [19:0] addr;

  int checks = 0, errors = 0, req_count = 0;
  req_t        exp_req[$];
  logic [15:0] exp_pop[$];
  logic [15:0] mem[int];
  logic [15:0] ref_mem[int];
  logic [15:0] msp = 0;

  always #4 clk = ~clk;  // 125 MHz

  seg_stack_unit i_seg_stack_unit (
    .clk_i(clk), .rst_ni, .seg_i(seg), .sp_load_i(ld), .sp_load_val_i(ld_val),
    .push_i(push), .pop_i(pop), .push_data_i(pdata), .pop_data_o(pop_data),
    .pop_valid_o(pop_valid), .busy_o(busy), .cmd_err_o(err), .sp_o(sp),
    .mem_req_o(req), .mem_we_o(we), .mem_addr_o(addr), .mem_wdata_o(wdata),
    .mem_rdata_i(rdata), .mem_rvalid_i(rvalid)
  );

  // memory model
  always @(posedge clk) begin
    rvalid <= req && !we;
    if (req && we) mem[int'(addr)] = wdata;
    if (req && !we) rdata <= mem.exists(int'(addr)) ? mem[int'(addr)] : 16'h0;
  end

  function automatic logic [19:0] phys(logic [15:0] s, logic [15:0] o);
    logic [19:0] a = {s, 4'h0};
    logic [19:0] b = {4'h0, o};
    return a + b;
  endfunction

  task automatic check(string r, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", r, act, exp);
    end
  endtask

  // monitor
  always @(negedge clk) if (rst_ni) begin
    if (req) begin
      req_t e;
      req_count++;
      if (exp_req.size() == 0) check("R7 unexpected request", {12'h0, addr}, 32'hFFFFFFFF);
      else begin
        e = exp_req.pop_front();
        check("R2/R3/R6 request kind", {31'h0, we}, {31'h0, e.we});
        check("R3 request address", {12'h0, addr}, {12'h0, e.addr});
        if (e.we) check("R2 write data", {16'h0, wdata}, {16'h0, e.data});
      end
    end
    if (pop_valid) begin
      if (exp_pop.size() == 0) check("R4 unexpected pop", {16'h0, pop_data}, 32'hFFFFFFFF);
      else check("R4/R5 pop data", {16'h0, pop_data}, {16'h0, exp_pop.pop_front()});
    end
  end

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic do_push(logic [15:0] d);
    @(negedge clk);
    push = 1; pdata = d;
    msp = msp - 16'd2;
    exp_req.push_back('{1'b1, phys(seg, msp), d});
    ref_mem[int'(phys(seg, msp))] = d;
    @(negedge clk);
    push = 0;
    check("R7 busy after accept", {31'h0, busy}, 32'h1);
    wait_idle();
    check("R2 pointer after push", {16'h0, sp}, {16'h0, msp});
  endtask

  task automatic do_pop();
    logic [19:0] a = phys(seg, msp);
    @(negedge clk);
    pop = 1;
    exp_req.push_back('{1'b0, a, 16'h0});
    exp_pop.push_back(ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : 16'h0);
    @(negedge clk);
    pop = 0;
    wait_idle();
    check("R4 pop_valid on completion", {31'h0, pop_valid}, 32'h1);
    msp = msp + 16'd2;
    @(negedge clk);
    check("R4 pointer after pop", {16'h0, sp}, {16'h0, msp});
    check("R4 pop_valid single cycle", {31'h0, pop_valid}, 32'h0);
  endtask

  task automatic do_load(logic [15:0] v);
    @(negedge clk);
    ld = 1; ld_val = v; msp = v;
    @(negedge clk);
    ld = 0;
    check("R9 pointer load", {16'h0, sp}, {16'h0, v});
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 sp reset", {16'h0, sp}, 32'h0);
    check("R1 busy reset", {31'h0, busy}, 32'h0);
    check("R1 req reset", {31'h0, req}, 32'h0);
    check("R1 pop_valid reset", {31'h0, pop_valid}, 32'h0);
    check("R1 err reset", {31'h0, err}, 32'h0);

    // R3 worked example: 08F1:0100 -> 09010
    seg = 16'h08F1;
    do_load(16'h0102);
    do_push(16'hAAAA);
    check("R3 example address", {12'h0, phys(16'h08F1, 16'h0100)}, 32'h09010);

    // R5 LIFO
    do_push(16'h1111);
    do_push(16'h2222);
    do_push(16'h3333);
    do_pop(); do_pop(); do_pop();

    // R6 popped cell persists; next push reuses address 0900Eh
    check("R6 cell kept", {16'h0, mem[int'(20'h0900E)]}, 32'h1111);
    do_push(16'h4444);
    check("R6 overwrite", {16'h0, mem[int'(20'h0900E)]}, 32'h4444);

    // R7 strobes held while busy
    n = req_count;
    @(negedge clk);
    push = 1; pdata = 16'h5555;
    msp = msp - 16'd2;
    exp_req.push_back('{1'b1, phys(seg, msp), 16'h5555});
    ref_mem[int'(phys(seg, msp))] = 16'h5555;
    @(negedge clk);
    pdata = 16'h6666;
    @(negedge clk);
    push = 0;
    wait_idle();
    @(negedge clk);
    check("R7 one request while busy", req_count - n, 1);
    check("R7 pointer single step", {16'h0, sp}, {16'h0, msp});

    // R8 clash
    n = req_count;
    @(negedge clk);
    push = 1; pop = 1;
    @(negedge clk);
    push = 0; pop = 0;
    check("R8 err pulse", {31'h0, err}, 32'h1);
    check("R8 not busy", {31'h0, busy}, 32'h0);
    @(negedge clk);
    check("R8 err single cycle", {31'h0, err}, 32'h0);
    check("R8 no request", req_count - n, 0);
    check("R8 pointer unchanged", {16'h0, sp}, {16'h0, msp});

    // R9 load wins over push
    n = req_count;
    @(negedge clk);
    ld = 1; ld_val = 16'h0200; push = 1; msp = 16'h0200;
    @(negedge clk);
    ld = 0; push = 0;
    check("R9 load value", {16'h0, sp}, 32'h0200);
    check("R9 push ignored busy", {31'h0, busy}, 32'h0);
    @(negedge clk);
    check("R9 push ignored req", req_count - n, 0);

    // R10 wrap
    seg = 16'hFFFF;
    do_load(16'h0000);
    do_push(16'h7777);
    check("R10 pointer wrap", {16'h0, sp}, 32'hFFFE);
    check("R10 address wrap", {16'h0, mem[int'(20'h0FFEE)]}, 32'h7777);
    do_pop();
    check("R10 pointer back", {16'h0, sp}, 32'h0000);

    repeat (3) @(negedge clk);
    check("R5 queues drained", exp_req.size() + exp_pop.size(), 0);
    finish_run();
  end
endmodule